// File: doc/BRIEF.md
# Stepping Wiper Position Bank

This block keeps the live tap position of a bank of digitally controlled potentiometers, one register per pot. The register of a pot can be rewritten from the host, reloaded from one of that pot's stored settings, reloaded across all pots at once, or nudged one tap at a time by a stream of clock pulses. After reset, every pot comes back to its stored setting number zero. The command decoder and the nonvolatile store sit outside. The decoder sends load strobes, a pot index, a register index, a step-session level, the serial clock and the serial data bit. The store presents all of its settings on one flat bus.

A small sequencer has three states. SEQ_PRELOAD is entered from reset and lasts one clock. It leaves by the transition PRELOAD_DONE to SEQ_IDLE, in which loads are accepted. START_STEP moves from SEQ_IDLE to SEQ_STEP when the step-session level is high, and latches the pot index at that moment. END_STEP returns to SEQ_IDLE when the level falls. A parallel decoder turns the wiper of a pot picked by the viewer index into a one-hot tap select.

Top module: `wiper_bank`

## Requirements
- R1: `tap_sel` is one-hot. Its set bit index equals the wiper value of pot `view_pot`: value 00h sets bit 0 (low end) and FFh sets bit 255 (high end).
- R2: While `rst_n` is low every wiper reads 0. On the first rising clock with `rst_n` high, pot p loads stored setting 0. Setting r of pot p is `dr_flat[(p*4+r)*8 +: 8]`.
- R3: In SEQ_IDLE, `wr_en` loads `wr_data` into pot `cmd_pot` at the next clock. The other pots keep their values.
- R4: In SEQ_IDLE, `xfr_en` loads pot `cmd_pot` from its own setting `cmd_reg` at the next clock.
- R5: In SEQ_IDLE, `gxfr_en` loads every pot p from its setting `cmd_reg` at the next clock.
- R6: When strobes coincide, `gxfr_en` wins over `xfr_en`, and `xfr_en` wins over `wr_en`.
- R7: In SEQ_STEP, a clock at which `sck` is 1 and was 0 at the previous clock steps the latched pot at that same clock. The step is +1 if `si` is 1 and -1 if `si` is 0.
- R8: START_STEP latches `cmd_pot` when `step_mode` is high in SEQ_IDLE. Stepping then goes on for any number of pulses. END_STEP returns to SEQ_IDLE when `step_mode` is low.
- R9: Stepping saturates: up at FFh and down at 00h leave the value unchanged.
- R10: Load strobes are ignored in SEQ_STEP and SEQ_PRELOAD. `sck` edges are ignored in SEQ_IDLE.
- R11: With no load, preload or step, every wiper holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| dr_flat | input | 128 | All stored settings; setting r of pot p at bits (p*4+r)*8 |
| cmd_pot | input | 2 | Pot index for single loads and step sessions |
| cmd_reg | input | 2 | Stored-setting index for transfers |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write value |
| xfr_en | input | 1 | Single-pot transfer strobe |
| gxfr_en | input | 1 | All-pot transfer strobe |
| step_mode | input | 1 | High while a step session is open |
| sck | input | 1 | Serial clock, already synchronous to clk |
| si | input | 1 | Step direction, 1 = toward high end |
| view_pot | input | 2 | Pot whose wiper drives tap_sel |
| wiper_flat | output | 32 | All wiper values, pot p at bits p*8 |
| tap_sel | output | 256 | One-hot tap select of the viewed pot |

## Verification
The bench uses the default parameters: four pots, 8-bit wipers and four stored settings per pot. With these values, a host write can place a wiper at FDh or 01h, so both saturation ends are reached within three pulses. Every one of the 256 tap bits is also a real output that a wrong decode would disturb. A behavioural model follows the three sequencer states. Each clock it compares all wipers and the one-hot tap select against the model while loads, transfers, coinciding strobes and step sessions on two different pots are applied.

// File: rtl/pot_pkg.sv
package pot_pkg;
    typedef enum logic [1:0] {
        SEQ_PRELOAD = 2'd0,
        SEQ_IDLE    = 2'd1,
        SEQ_STEP    = 2'd2
    } seq_state_t;
endpackage

// File: rtl/wiper_seq.sv
module wiper_seq
    import pot_pkg::*;
#(
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_mode,
    input  logic [PW-1:0] cmd_pot,
    input  logic          sck,
    output logic          preload,
    output logic          accept,
    output logic          step_active,
    output logic [PW-1:0] step_pot,
    output logic          sck_rise
);
    seq_state_t state_q, state_d;
    logic       sck_q;
    logic [PW-1:0] pot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_PRELOAD;
            sck_q   <= 1'b0;
            pot_q   <= '0;
        end else begin
            state_q <= state_d;
            sck_q   <= sck;
            if (state_q == SEQ_IDLE && step_mode)
                pot_q <= cmd_pot;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_PRELOAD: state_d = SEQ_IDLE;                          // PRELOAD_DONE
            SEQ_IDLE:    if (step_mode)  state_d = SEQ_STEP;          // START_STEP
            SEQ_STEP:    if (!step_mode) state_d = SEQ_IDLE;          // END_STEP
            default:     state_d = SEQ_PRELOAD;
        endcase
    end

    always_comb begin
        preload     = 1'b0;
        accept      = 1'b0;
        step_active = 1'b0;
        unique case (state_q)
            SEQ_PRELOAD: preload     = 1'b1;
            SEQ_IDLE:    accept      = 1'b1;
            SEQ_STEP:    step_active = 1'b1;
            default:     preload     = 1'b0;
        endcase
    end

    assign step_pot = pot_q;
    assign sck_rise = sck & ~sck_q;

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && !step_mode) |=> (state_q == SEQ_IDLE));

    // R8
    step_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && step_mode) |=> (state_q == SEQ_STEP && pot_q == $past(cmd_pot)));

    // R2
    preload_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_PRELOAD) |=> (state_q == SEQ_IDLE));
endmodule

// File: rtl/wiper_cell.sv
module wiper_cell #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preload,
    input  logic [WIDTH-1:0] pre_val,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] MINV = '0;

    logic [WIDTH-1:0] q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_r <= '0;
        else if (preload)
            q_r <= pre_val;
        else if (load)
            q_r <= load_val;
        else if (step_up && q_r != MAXV)
            q_r <= q_r + 1'b1;
        else if (step_dn && q_r != MINV)
            q_r <= q_r - 1'b1;
    end

    assign q = q_r;

    // R9
    no_wrap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !load && !preload && q_r == MAXV) |=> (q_r == MAXV));

    // R9
    no_wrap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && !load && !preload && q_r == MINV) |=> (q_r == MINV));

    // R7
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !load && !preload && q_r != MAXV) |=> (q_r == $past(q_r) + 1'b1));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preload && !load && !step_up && !step_dn) |=> $stable(q_r));

    // R2
    preload_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preload |=> (q_r == $past(pre_val)));
endmodule

// File: rtl/wiper_tap_dec.sv
module wiper_tap_dec #(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WIDTH-1:0]      value,
    output logic [(1<<WIDTH)-1:0] onehot
);
    localparam int TAPS = 1 << WIDTH;

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign onehot[t] = (value == WIDTH'(t));
    end

    // R1
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(onehot) == 1);
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import pot_pkg::*;
#(
    parameter int NUM_POTS = 4,
    parameter int NUM_REGS = 4,
    parameter int WIDTH    = 8,
    localparam int PW      = $clog2(NUM_POTS),
    localparam int RW      = $clog2(NUM_REGS),
    localparam int TAPS    = 1 << WIDTH
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_POTS*NUM_REGS*WIDTH-1:0] dr_flat,
    input  logic [PW-1:0]                cmd_pot,
    input  logic [RW-1:0]                cmd_reg,
    input  logic                         wr_en,
    input  logic [WIDTH-1:0]             wr_data,
    input  logic                         xfr_en,
    input  logic                         gxfr_en,
    input  logic                         step_mode,
    input  logic                         sck,
    input  logic                         si,
    input  logic [PW-1:0]                view_pot,
    output logic [NUM_POTS*WIDTH-1:0]    wiper_flat,
    output logic [TAPS-1:0]              tap_sel
);
    logic          preload;
    logic          accept;
    logic          step_active;
    logic [PW-1:0] step_pot;
    logic          sck_rise;

    wiper_seq #(.PW(PW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_mode  (step_mode),
        .cmd_pot    (cmd_pot),
        .sck        (sck),
        .preload    (preload),
        .accept     (accept),
        .step_active(step_active),
        .step_pot   (step_pot),
        .sck_rise   (sck_rise)
    );

    for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
        logic             hit;
        logic             ld;
        logic [WIDTH-1:0] ld_val;
        logic [WIDTH-1:0] sel_dr;
        logic [WIDTH-1:0] zero_dr;
        logic             up;
        logic             dn;

        assign hit     = (cmd_pot == PW'(p));
        assign sel_dr  = dr_flat[(p*NUM_REGS + int'(cmd_reg))*WIDTH +: WIDTH];
        assign zero_dr = dr_flat[(p*NUM_REGS)*WIDTH +: WIDTH];
        assign ld      = accept & (gxfr_en | (hit & (xfr_en | wr_en)));
        assign ld_val  = (gxfr_en | xfr_en) ? sel_dr : wr_data;
        assign up      = step_active & sck_rise & si  & (step_pot == PW'(p));
        assign dn      = step_active & sck_rise & ~si & (step_pot == PW'(p));

        wiper_cell #(.WIDTH(WIDTH)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .preload (preload),
            .pre_val (zero_dr),
            .load    (ld),
            .load_val(ld_val),
            .step_up (up),
            .step_dn (dn),
            .q       (wiper_flat[p*WIDTH +: WIDTH])
        );
    end

    logic [WIDTH-1:0] view_val;
    assign view_val = wiper_flat[int'(view_pot)*WIDTH +: WIDTH];

    wiper_tap_dec #(.WIDTH(WIDTH)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .value (view_val),
        .onehot(tap_sel)
    );

    // R10
    step_ignores_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_active && !sck_rise) |=> $stable(wiper_flat));

    // R10
    idle_ignores_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wr_en && !xfr_en && !gxfr_en) |=> $stable(wiper_flat));
endmodule

// File: tb/wiper_bank_test.sv
`timescale 1ns/1ps
module wiper_bank_test;
    localparam int NP = 4;
    localparam int NR = 4;
    localparam int W  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NP*NR*W-1:0] dr_flat;
    logic [1:0]     cmd_pot = '0;
    logic [1:0]     cmd_reg = '0;
    logic           wr_en = 1'b0;
    logic [W-1:0]   wr_data = '0;
    logic           xfr_en = 1'b0;
    logic           gxfr_en = 1'b0;
    logic           step_mode = 1'b0;
    logic           sck = 1'b0;
    logic           si = 1'b0;
    logic [1:0]     view_pot = '0;
    logic [NP*W-1:0] wiper_flat;
    logic [255:0]   tap_sel;

    int errors = 0;
    int checks = 0;
    string phase = "R2 reset";

    always #2.5 clk = ~clk;

    wiper_bank uut (
        .clk(clk), .rst_n(rst_n), .dr_flat(dr_flat), .cmd_pot(cmd_pot),
        .cmd_reg(cmd_reg), .wr_en(wr_en), .wr_data(wr_data), .xfr_en(xfr_en),
        .gxfr_en(gxfr_en), .step_mode(step_mode), .sck(sck), .si(si),
        .view_pot(view_pot), .wiper_flat(wiper_flat), .tap_sel(tap_sel)
    );

    function automatic int stored(int p, int r);
        return int'(dr_flat[(p*NR + r)*W +: W]);
    endfunction

    // behavioural reference model
    int mw[NP];
    int mstate = 0;
    int mpot = 0;
    int mprev = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) mw[p] = 0;
            mstate = 0; mpot = 0; mprev = 0;
        end else begin
            if (mstate == 0) begin
                for (int p = 0; p < NP; p++) mw[p] = stored(p, 0);
                mstate = 1;
            end else if (mstate == 1) begin
                if (gxfr_en) begin
                    for (int p = 0; p < NP; p++) mw[p] = stored(p, int'(cmd_reg));
                end else if (xfr_en) begin
                    mw[cmd_pot] = stored(int'(cmd_pot), int'(cmd_reg));
                end else if (wr_en) begin
                    mw[cmd_pot] = int'(wr_data);
                end
                if (step_mode) begin mstate = 2; mpot = int'(cmd_pot); end
            end else begin
                if (sck && mprev == 0) begin
                    if (si && mw[mpot] < 255) mw[mpot] = mw[mpot] + 1;
                    else if (!si && mw[mpot] > 0) mw[mpot] = mw[mpot] - 1;
                end
                if (!step_mode) mstate = 1;
            end
            mprev = int'(sck);
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++)
            check(phase, int'(wiper_flat[p*W +: W]), mw[p]);
        checks++;
        if (tap_sel !== (256'b1 << mw[view_pot])) begin
            errors++;
            $display("FAIL R1 tap (%s): actual=%h expected bit %0d", phase, tap_sel, mw[view_pot]);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(logic dir);
        sck = 1'b1; si = dir; tick(1);
        sck = 1'b0; tick(1);
    endtask

    initial begin
        for (int p = 0; p < NP; p++)
            for (int r = 0; r < NR; r++)
                dr_flat[(p*NR + r)*W +: W] = W'((p*64 + r*17 + 5) & 255);
        tick(3);
        @(negedge clk);
        check("R2 in reset", int'(wiper_flat), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < NP; p++)
            check("R2 preload", int'(wiper_flat[p*W +: W]), stored(p, 0));
        tick(1);

        phase = "R3 write";
        cmd_pot = 2; wr_data = 8'hA5; wr_en = 1; tick(1); wr_en = 0;
        @(negedge clk);
        check("R3 write", int'(wiper_flat[2*W +: W]), 8'hA5);
        check("R3 others", int'(wiper_flat[0 +: W]), stored(0, 0));
        tick(1);

        phase = "R4 transfer";
        cmd_pot = 1; cmd_reg = 3; xfr_en = 1; tick(1); xfr_en = 0;
        @(negedge clk);
        check("R4 transfer", int'(wiper_flat[1*W +: W]), stored(1, 3));
        tick(1);

        phase = "R5 global";
        cmd_reg = 2; gxfr_en = 1; tick(1); gxfr_en = 0;
        @(negedge clk);
        for (int p = 0; p < NP; p++)
            check("R5 global", int'(wiper_flat[p*W +: W]), stored(p, 2));
        tick(1);

        phase = "R6 priority";
        cmd_pot = 3; cmd_reg = 1; wr_data = 8'h11; wr_en = 1; xfr_en = 1; tick(1);
        wr_en = 0; xfr_en = 0;
        @(negedge clk);
        check("R6 xfr over wr", int'(wiper_flat[3*W +: W]), stored(3, 1));
        cmd_reg = 0; wr_en = 1; xfr_en = 1; gxfr_en = 1; tick(1);
        wr_en = 0; xfr_en = 0; gxfr_en = 0;
        @(negedge clk);
        check("R6 global wins", int'(wiper_flat[3*W +: W]), stored(3, 0));
        tick(1);

        phase = "R10 idle sck";
        pulse(1); pulse(0); pulse(1);
        @(negedge clk);
        check("R10 idle sck", int'(wiper_flat[3*W +: W]), stored(3, 0));
        tick(1);

        phase = "R7 step up";
        cmd_pot = 0; wr_data = 8'hFD; wr_en = 1; tick(1); wr_en = 0;
        view_pot = 0;
        step_mode = 1; tick(1);
        cmd_pot = 2;
        pulse(1);
        @(negedge clk);
        check("R7 step up", int'(wiper_flat[0 +: W]), 8'hFE);
        tick(1);
        phase = "R9 saturate high";
        pulse(1); pulse(1); pulse(1);
        @(negedge clk);
        check("R9 saturate high", int'(wiper_flat[0 +: W]), 8'hFF);
        check("R1 tap top", int'(tap_sel[255]), 1);
        tick(1);
        phase = "R10 load in step";
        wr_en = 1; wr_data = 8'h00; gxfr_en = 1; tick(1); wr_en = 0; gxfr_en = 0;
        @(negedge clk);
        check("R10 load in step", int'(wiper_flat[0 +: W]), 8'hFF);
        tick(1);
        phase = "R8 many steps";
        for (int i = 0; i < 6; i++) pulse(0);
        @(negedge clk);
        check("R8 many steps", int'(wiper_flat[0 +: W]), 8'hF9);
        tick(1);
        step_mode = 0; tick(1);
        phase = "R8 after end";
        pulse(0);
        @(negedge clk);
        check("R8 after end", int'(wiper_flat[0 +: W]), 8'hF9);
        tick(1);

        phase = "R9 saturate low";
        cmd_pot = 1; wr_data = 8'h01; wr_en = 1; tick(1); wr_en = 0;
        view_pot = 1;
        step_mode = 1; tick(1);
        pulse(0); pulse(0); pulse(0);
        @(negedge clk);
        check("R9 saturate low", int'(wiper_flat[1*W +: W]), 0);
        check("R1 tap bottom", int'(tap_sel[0]), 1);
        tick(1);
        phase = "R7 step pot only";
        check("R7 step pot only", int'(wiper_flat[0 +: W]), 8'hF9);
        pulse(1);
        step_mode = 0; tick(2);

        phase = "R1 view sweep";
        for (int v = 0; v < NP; v++) begin
            view_pot = 2'(v); tick(1);
        end
        phase = "R11 hold";
        tick(10);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule